// File: doc/BRIEF.md
# Tracking ADC Up/Down Controller

This block is the digital half of a tracking analog-to-digital converter. It holds an up/down counter whose value drives an external DAC, and it reads one comparator bit that reports whether the analog input is above the DAC output. On each enabled step the counter moves one LSB toward the input. It is never cleared between samples, so each new estimate starts from the previous one. When the input is steady, the code settles into a one-LSB oscillation around it.

The counter saturates at both ends instead of wrapping. A range alarm goes high when a step is refused at either end. A two-bit direction lock limits movement to upward only or downward only. Upward-only turns the block into a peak detector and downward-only into a valley detector. The comparator bit crosses into the clock domain through a parameterised flop chain. A step-enable pin sets the tracking rate. The code is a level output with no handshake, and every pin is plain control or status.

Top module: `trk_adc_ctrl`

## Requirements
- R1: While rst_n is low, and after its release until the first step, dac_code is 0 and both hi_alarm and lo_alarm are 0.
- R2: With dir_lock 2'b00 or 2'b11 (follow), each cycle with step_en high adds 1 to dac_code if the synchronised in_above_dac is 1, and subtracts 1 if it is 0.
- R3: dac_code never wraps from all ones to 0. A cycle with step_en high that asks for an up step at all ones keeps the code and sets hi_alarm. Any later step_en cycle that does not refuse an up step clears it.
- R4: dac_code never wraps from 0 to all ones. A cycle with step_en high that asks for a down step at 0 keeps the code and sets lo_alarm. Any later step_en cycle that does not refuse a down step clears it.
- R5: In a cycle with step_en low and clear low, dac_code, hi_alarm and lo_alarm keep their values, whatever in_above_dac and dir_lock do.
- R6: With dir_lock 2'b01 (peak), down requests are ignored and dac_code never decreases. Up requests step as in R2.
- R7: With dir_lock 2'b10 (valley), up requests are ignored and dac_code never increases. Down requests step as in R2.
- R8: clear high at a clock edge loads dac_code with 0 and clears both alarms. It wins over step_en.
- R9: in_above_dac passes through SYNC_STAGES flops before it is used. With the default of 2, a new comparator value first steers the step at the third rising edge after it is applied.
- R10: In a closed loop with a steady input between codes T-1 and T, and steps spaced more than SYNC_STAGES cycles apart, dac_code settles to an alternation between T-1 and T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous load of code 0, clears the alarms |
| step_en | input | 1 | Allows one step in this cycle |
| in_above_dac | input | 1 | Comparator: 1 when the analog input is above the DAC output (asynchronous) |
| dir_lock | input | 2 | 00/11 follow, 01 peak (up only), 10 valley (down only) |
| dac_code | output | CODE_W | Current estimate, drives the DAC |
| hi_alarm | output | 1 | Up step refused at all ones |
| lo_alarm | output | 1 | Down step refused at zero |

## Verification
The assertions assume that rst_n is driven low from time zero and that dir_lock and clear are synchronous to clk. The comparator is the only asynchronous input. The bench changes every input half a period away from the rising edge. Before counting steps it holds in_above_dac stable with step_en low for SYNC_STAGES+1 cycles, so each step sees a known comparator value. The single exception is the latency test, which changes the comparator and step_en together on purpose.

// File: rtl/trk_pkg.sv
package trk_pkg;
  typedef enum logic [1:0] {
    LOCK_NONE   = 2'b00,
    LOCK_UP     = 2'b01,
    LOCK_DOWN   = 2'b10,
    LOCK_NONE_B = 2'b11
  } lock_e;

  typedef struct packed {
    logic up;
    logic dn;
  } step_req_t;
endpackage

// File: rtl/trk_sync.sv
module trk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/trk_dir.sv
module trk_dir
  import trk_pkg::*;
(
  input  logic      above,
  input  logic [1:0] lock,
  output step_req_t req
);
  lock_e lock_m;

  always_comb begin
    lock_m = lock_e'(lock);
    req.up = above;
    req.dn = ~above;
    case (lock_m)
      LOCK_UP:   req.dn = 1'b0;
      LOCK_DOWN: req.up = 1'b0;
      default:   ;
    endcase
  end
endmodule

// File: rtl/trk_counter.sv
module trk_counter
  import trk_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_en,
  input  step_req_t         req,
  output logic [CODE_W-1:0] code,
  output logic              hi_alarm,
  output logic              lo_alarm
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  logic at_top, at_bot;
  assign at_top = (code == CODE_MAX);
  assign at_bot = (code == CODE_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= CODE_MIN;
      hi_alarm <= 1'b0;
      lo_alarm <= 1'b0;
    end else if (clear) begin
      code     <= CODE_MIN;
      hi_alarm <= 1'b0;
      lo_alarm <= 1'b0;
    end else if (step_en) begin
      hi_alarm <= 1'b0;
      lo_alarm <= 1'b0;
      if (req.up) begin
        if (at_top) hi_alarm <= 1'b1;
        else        code <= code + 1'b1;
      end else if (req.dn) begin
        if (at_bot) lo_alarm <= 1'b1;
        else        code <= code - 1'b1;
      end
    end
  end
endmodule

// File: rtl/trk_adc_ctrl.sv
module trk_adc_ctrl
  import trk_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_en,
  input  logic              in_above_dac,
  input  logic [1:0]        dir_lock,
  output logic [CODE_W-1:0] dac_code,
  output logic              hi_alarm,
  output logic              lo_alarm
);
  logic      above_s;
  step_req_t req;

  trk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (in_above_dac),
    .q     (above_s)
  );

  trk_dir u_dir (
    .above (above_s),
    .lock  (dir_lock),
    .req   (req)
  );

  trk_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .step_en  (step_en),
    .req      (req),
    .code     (dac_code),
    .hi_alarm (hi_alarm),
    .lo_alarm (lo_alarm)
  );
endmodule

// File: rtl/trk_adc_ctrl_chk.sv
module trk_adc_ctrl_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clear,
  input logic              step_en,
  input logic [1:0]        dir_lock,
  input logic [CODE_W-1:0] dac_code,
  input logic              hi_alarm,
  input logic              lo_alarm
);
  localparam logic [CODE_W-1:0] TOP = '1;

  logic [CODE_W:0] code_w;
  assign code_w = {1'b0, dac_code};

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (code_w == $past(code_w) || code_w == $past(code_w) + 1'b1 ||
                code_w + 1'b1 == $past(code_w)));

  assert_no_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == TOP && !clear) |=> dac_code != '0);

  assert_hi_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hi_alarm |-> dac_code == TOP);

  assert_no_wrap_bot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == '0 && !clear) |=> dac_code != TOP);

  assert_lo_at_bot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_alarm |-> dac_code == '0);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !clear) |=> ($stable(dac_code) && $stable(hi_alarm) && $stable(lo_alarm)));

  assert_peak_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_lock == 2'b01 && !clear) |=> dac_code >= $past(dac_code));

  assert_valley_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_lock == 2'b10 && !clear) |=> dac_code <= $past(dac_code));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (dac_code == '0 && !hi_alarm && !lo_alarm));
endmodule

bind trk_adc_ctrl trk_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .step_en  (step_en),
  .dir_lock (dir_lock),
  .dac_code (dac_code),
  .hi_alarm (hi_alarm),
  .lo_alarm (lo_alarm)
);

// File: tb/trk_adc_ctrl_tb_top.sv
module trk_adc_ctrl_tb_top;
  localparam int W = 8;
  localparam int NV = 13;
  localparam int TGT = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic step_en = 1'b0;
  logic in_above_dac = 1'b0;
  logic [1:0] dir_lock = 2'b00;
  logic [W-1:0] dac_code;
  logic hi_alarm, lo_alarm;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trk_adc_ctrl #(.CODE_W(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step_en(step_en),
    .in_above_dac(in_above_dac), .dir_lock(dir_lock),
    .dac_code(dac_code), .hi_alarm(hi_alarm), .lo_alarm(lo_alarm)
  );

  // {lock[21:20], cmp[19], steps[18:10], code[9:2], hi[1], lo[0]}
  localparam logic [21:0] VEC [NV] = '{
    {2'b00, 1'b1, 9'd5,   8'd5,   1'b0, 1'b0},  // R2 up
    {2'b00, 1'b0, 9'd2,   8'd3,   1'b0, 1'b0},  // R2 down
    {2'b01, 1'b0, 9'd4,   8'd3,   1'b0, 1'b0},  // R6 down ignored
    {2'b01, 1'b1, 9'd3,   8'd6,   1'b0, 1'b0},  // R6 up allowed
    {2'b10, 1'b1, 9'd4,   8'd6,   1'b0, 1'b0},  // R7 up ignored
    {2'b10, 1'b0, 9'd2,   8'd4,   1'b0, 1'b0},  // R7 down allowed
    {2'b11, 1'b0, 9'd4,   8'd0,   1'b0, 1'b0},  // R2 alt follow code
    {2'b00, 1'b0, 9'd1,   8'd0,   1'b0, 1'b1},  // R4 refused at zero
    {2'b10, 1'b0, 9'd2,   8'd0,   1'b0, 1'b1},  // R4 valley at zero
    {2'b00, 1'b1, 9'd1,   8'd1,   1'b0, 1'b0},  // R4 alarm cleared
    {2'b00, 1'b1, 9'd254, 8'd255, 1'b0, 1'b0},  // R3 reach top
    {2'b00, 1'b1, 9'd3,   8'd255, 1'b1, 1'b0},  // R3 refused at top
    {2'b01, 1'b1, 9'd1,   8'd255, 1'b1, 1'b0}   // R3 peak at top
  };

  task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual code/hi/lo=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    logic [W-1:0] prev;
    logic seen_lo, seen_hi, loop_ok;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {dac_code, hi_alarm, lo_alarm}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {dac_code, hi_alarm, lo_alarm}, '0);

    for (int v = 0; v < NV; v++) begin
      dir_lock = VEC[v][21:20];
      in_above_dac = VEC[v][19];
      step_en = 1'b0;
      repeat (3) @(negedge clk);
      step_en = 1'b1;
      repeat (int'(VEC[v][18:10])) @(negedge clk);
      step_en = 1'b0;
      chk($sformatf("vector %0d (R2/R3/R4/R6/R7)", v),
          {dac_code, hi_alarm, lo_alarm}, VEC[v][9:0]);
    end

    // R5: no step, toggling comparator and lock
    for (int i = 0; i < 6; i++) begin
      in_above_dac = ~in_above_dac;
      dir_lock = 2'(i);
      @(negedge clk);
    end
    chk("R5 hold", {dac_code, hi_alarm, lo_alarm}, {8'd255, 1'b1, 1'b0});

    // R9: comparator latency
    dir_lock = 2'b00;
    in_above_dac = 1'b0;
    repeat (3) @(negedge clk);
    in_above_dac = 1'b1;
    step_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 old value for two edges", {dac_code, hi_alarm, lo_alarm}, {8'd253, 2'b00});
    @(negedge clk);
    step_en = 1'b0;
    chk("R9 new value at third edge", {dac_code, hi_alarm, lo_alarm}, {8'd254, 2'b00});

    // R8: clear beats step
    clear = 1'b1;
    step_en = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    step_en = 1'b0;
    chk("R8 clear", {dac_code, hi_alarm, lo_alarm}, '0);

    // R10: closed loop, input between TGT-1 and TGT
    seen_lo = 1'b0;
    seen_hi = 1'b0;
    loop_ok = 1'b1;
    prev = dac_code;
    for (int it = 0; it < 240; it++) begin
      in_above_dac = (int'(dac_code) < TGT);
      repeat (3) @(negedge clk);
      step_en = 1'b1;
      @(negedge clk);
      step_en = 1'b0;
      if (it >= 220) begin
        if (int'(dac_code) == TGT - 1) seen_lo = 1'b1;
        else if (int'(dac_code) == TGT) seen_hi = 1'b1;
        else loop_ok = 1'b0;
        if (dac_code == prev) loop_ok = 1'b0;
      end
      prev = dac_code;
    end
    chk("R10 alternation", {8'(loop_ok), seen_lo, seen_hi}, {8'd1, 2'b11});

    finish_run();
  end
endmodule